// File: doc/BRIEF.md
# Scaled Accumulator Add Unit

This unit carries out the add-to-accumulator instruction group of a 16-bit fixed-point processor that keeps a 32-bit accumulator. Each cycle it may accept one opcode word. It decodes the word into an operand source, a left-scaling amount and an add mode. It widens the 16-bit operand to 32 bits, shifts it into place and adds it to the accumulator. It also replaces the carry and overflow flags. Besides the plain add, the unit has these modes:
- add with the carry flag as carry-in;
- add of an unsigned value to the low half of the accumulator;
- add scaled by a shift amount held in a temporary register;
- absolute value of the accumulator, which saturates.

Operand fetch is done elsewhere. A memory operand arrives on `mem_data` in the same cycle as its opcode. The long-immediate form takes two words: the unit accepts the opcode, then waits until `ext_valid` presents the constant on `ext_word`. All results are registered. They are visible after the clock edge that accepts the executing word.

Top module: `acc_add_unit`

## Requirements
- R1: After reset, acc is 0, carry is 0, ovf is 0 and illegal is 0.
- R2: Opcode 0010 ssss xxxx xxxx (bits 15..12 = 0010) adds the widened `mem_data` shifted left by the amount s in bits 11..8 (0 to 15). It completes in one cycle.
- R3: Opcode 1011 1111 1001 ssss latches the shift amount s from bits 3..0 and leaves acc and flags unchanged. While the unit waits, op_valid is ignored. On the edge that samples ext_valid=1, it adds the widened `ext_word` shifted left by s.
- R4: Opcode 0x61xx adds the widened `mem_data` shifted left by 16.
- R5: Opcode 0xB8ii adds the 8-bit immediate ii (bits 7..0), zero-extended and unshifted.
- R6: Opcode 0x60xx adds the widened, unshifted `mem_data` plus the current carry flag.
- R7: Opcode 0x62xx adds `mem_data` zero-extended and unshifted, whatever the value of sxm_en.
- R8: Opcode 0x63xx adds the widened `mem_data` shifted left by `treg_shift` (0 to 15).
- R9: Widening in R2, R3, R4, R6 and R8 is sign extension when sxm_en=1 and zero extension when sxm_en=0.
- R10: Every executed add sets carry to the unsigned carry out of bit 31 and ovf to signed overflow of the 32-bit sum. An add of operands with opposite signs never sets ovf.
- R11: Opcode 0xBE00 replaces acc with its absolute value and clears carry. ovf is 0, except that acc = 0x80000000 becomes 0x7FFFFFFF with ovf=1.
- R12: Any other opcode accepted with op_valid leaves acc, carry and ovf unchanged and raises illegal for the following cycle. Any accepted legal word, or any idle cycle, returns illegal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An opcode word is presented |
| op_word | input | 16 | Opcode word |
| mem_data | input | 16 | Memory operand for the opcode presented |
| ext_valid | input | 1 | Second word of a long-immediate instruction is presented |
| ext_word | input | 16 | Long-immediate constant |
| sxm_en | input | 1 | 1 = sign-extend operands, 0 = zero-extend |
| treg_shift | input | 4 | Shift amount from the temporary register |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry flag |
| ovf | output | 1 | Overflow flag |
| illegal | output | 1 | The previous accepted word was not in the group |

## Verification
The hardest state to reach is absolute value of the most negative accumulator. Random adds almost never land on 0x80000000. The bench therefore resets, applies a sign-extended 0x8000 with the fixed shift of 16, and then applies the absolute-value opcode. The waiting cycle of the long-immediate form is also forced on purpose: an illegal opcode is presented during that wait, which checks that it is ignored. Around these directed cases, random opcodes, operands, shift amounts and extension modes are checked against a bench model.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned ACC_W = 32;
  localparam int unsigned SH_W  = $clog2(OP_W) + 1;
  localparam int unsigned IMM_W = OP_W / 2;

  typedef enum logic [3:0] {
    M_ADD, M_LONG, M_SH16, M_IMM8, M_ADDC, M_ADDS, M_ADDT, M_ABS, M_NONE
  } acu_mode_e;

  typedef struct packed {
    acu_mode_e       mode;
    logic [SH_W-1:0] shift;
    logic            illegal;
  } acu_dec_t;

  function automatic logic [ACC_W-1:0] f_widen(input logic [OP_W-1:0] d, input logic zext);
    return zext ? {{(ACC_W-OP_W){1'b0}}, d} : {{(ACC_W-OP_W){d[OP_W-1]}}, d};
  endfunction

  function automatic logic [ACC_W-1:0] f_scale(input logic [ACC_W-1:0] v, input logic [SH_W-1:0] sh);
    return v << sh;
  endfunction

  // returns {carry, overflow, sum}
  function automatic logic [ACC_W+1:0] f_add(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b,
                                             input logic cin);
    logic [ACC_W:0] s;
    logic           v;
    s = {1'b0, a} + {1'b0, b} + {{ACC_W{1'b0}}, cin};
    v = (a[ACC_W-1] == b[ACC_W-1]) && (s[ACC_W-1] != a[ACC_W-1]);
    return {s[ACC_W], v, s[ACC_W-1:0]};
  endfunction

  // returns {overflow, magnitude}
  function automatic logic [ACC_W:0] f_abs(input logic [ACC_W-1:0] a);
    logic [ACC_W-1:0] most_neg;
    most_neg = {1'b1, {(ACC_W-1){1'b0}}};
    if (a == most_neg) return {1'b1, ~most_neg};
    if (a[ACC_W-1])    return {1'b0, (~a) + 1'b1};
    return {1'b0, a};
  endfunction
endpackage

// File: rtl/acu_decode.sv
module acu_decode
  import acu_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [SH_W-2:0]  treg_i,
  output acu_dec_t         dec_o
);
  always_comb begin
    dec_o.mode    = M_NONE;
    dec_o.shift   = '0;
    dec_o.illegal = 1'b0;
    if (op_i[15:12] == 4'b0010) begin
      dec_o.mode  = M_ADD;
      dec_o.shift = {1'b0, op_i[11:8]};
    end else if (op_i[15:4] == 12'hBF9) begin
      dec_o.mode  = M_LONG;
      dec_o.shift = {1'b0, op_i[3:0]};
    end else if (op_i == 16'hBE00) begin
      dec_o.mode  = M_ABS;
    end else begin
      unique case (op_i[15:8])
        8'h60: dec_o.mode = M_ADDC;
        8'h61: begin
          dec_o.mode  = M_SH16;
          dec_o.shift = SH_W'(OP_W);
        end
        8'h62: dec_o.mode = M_ADDS;
        8'h63: begin
          dec_o.mode  = M_ADDT;
          dec_o.shift = {1'b0, treg_i};
        end
        8'hB8: dec_o.mode = M_IMM8;
        default: dec_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/acu_shifter.sv
module acu_shifter
  import acu_pkg::*;
(
  input  logic [OP_W-1:0]  data_i,
  input  logic             zext_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [ACC_W-1:0] addend_o
);
  always_comb addend_o = f_scale(f_widen(data_i, zext_i), shift_i);
endmodule

// File: rtl/acu_alu.sv
module acu_alu
  import acu_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             cin_i,
  input  logic             abs_i,
  output logic [ACC_W-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [ACC_W+1:0] add_r;
  logic [ACC_W:0]   abs_r;

  always_comb begin
    add_r = f_add(acc_i, addend_i, cin_i);
    abs_r = f_abs(acc_i);
    if (abs_i) begin
      res_o   = abs_r[ACC_W-1:0];
      carry_o = 1'b0;
      ovf_o   = abs_r[ACC_W];
    end else begin
      res_o   = add_r[ACC_W-1:0];
      carry_o = add_r[ACC_W+1];
      ovf_o   = add_r[ACC_W];
    end
  end
endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
  import acu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_word,
  input  logic [OP_W-1:0]   mem_data,
  input  logic              ext_valid,
  input  logic [OP_W-1:0]   ext_word,
  input  logic              sxm_en,
  input  logic [SH_W-2:0]   treg_shift,
  output logic [ACC_W-1:0]  acc,
  output logic              carry,
  output logic              ovf,
  output logic              illegal
);
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MAX = ~ACC_MIN;

  logic [ACC_W-1:0] acc_q;
  logic             carry_q, ovf_q, illegal_q, wait_q;
  logic [SH_W-2:0]  pend_shift_q;

  acu_dec_t         dec;
  logic             take_op, fire_single, fire_second, exec_fire;
  logic             ev_illegal, ev_long_start, ev_abs;
  acu_mode_e        exec_mode;
  logic [SH_W-1:0]  exec_shift;
  logic [OP_W-1:0]  exec_data;
  logic             exec_zext, exec_cin;
  logic [ACC_W-1:0] addend, alu_res;
  logic             alu_c, alu_v;

  acu_decode u_dec (.op_i(op_word), .treg_i(treg_shift), .dec_o(dec));

  // named events, also used by the assertions
  always_comb begin
    take_op       = op_valid && !wait_q;
    fire_second   = wait_q && ext_valid;
    ev_illegal    = take_op && dec.illegal;
    ev_long_start = take_op && !dec.illegal && (dec.mode == M_LONG);
    fire_single   = take_op && !dec.illegal && (dec.mode != M_LONG);
    exec_fire     = fire_single || fire_second;
    exec_mode     = fire_second ? M_LONG : dec.mode;
    ev_abs        = fire_single && (exec_mode == M_ABS);
  end

  always_comb begin
    exec_shift = fire_second ? {1'b0, pend_shift_q} : dec.shift;
    if (fire_second)                exec_data = ext_word;
    else if (exec_mode == M_IMM8)   exec_data = {{(OP_W-IMM_W){1'b0}}, op_word[IMM_W-1:0]};
    else                            exec_data = mem_data;
    exec_zext = !sxm_en || (exec_mode == M_ADDS) || (exec_mode == M_IMM8);
    exec_cin  = (exec_mode == M_ADDC) && carry_q;
  end

  acu_shifter u_shf (.data_i(exec_data), .zext_i(exec_zext), .shift_i(exec_shift),
                     .addend_o(addend));

  acu_alu u_alu (.acc_i(acc_q), .addend_i(addend), .cin_i(exec_cin),
                 .abs_i(exec_mode == M_ABS), .res_o(alu_res), .carry_o(alu_c), .ovf_o(alu_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q        <= '0;
      carry_q      <= 1'b0;
      ovf_q        <= 1'b0;
      illegal_q    <= 1'b0;
      wait_q       <= 1'b0;
      pend_shift_q <= '0;
    end else begin
      illegal_q <= ev_illegal;
      if (exec_fire) begin
        acc_q   <= alu_res;
        carry_q <= alu_c;
        ovf_q   <= alu_v;
      end
      if (ev_long_start) begin
        wait_q       <= 1'b1;
        pend_shift_q <= dec.shift[SH_W-2:0];
      end else if (fire_second) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign acc     = acc_q;
  assign carry   = carry_q;
  assign ovf     = ovf_q;
  assign illegal = illegal_q;

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> $stable(acc_q) && $stable(carry_q) && $stable(ovf_q) && illegal_q); // R12
  AST_LONG_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_long_start |=> wait_q && $stable(acc_q) && !illegal_q); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && !ext_valid |=> wait_q && $stable(acc_q) && !illegal_q); // R3
  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abs |=> !acc_q[ACC_W-1] && !carry_q); // R11
  AST_ABS_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abs && (acc_q == ACC_MIN) |=> (acc_q == ACC_MAX) && ovf_q); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire && (exec_mode != M_ABS) && (acc_q[ACC_W-1] != addend[ACC_W-1]) |=> !ovf_q); // R10
endmodule

// File: tb/acc_add_unit_tb.sv
`timescale 1ns/1ps
module acc_add_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, ext_valid = 1'b0, sxm_en = 1'b1;
  logic [15:0] op_word = '0, mem_data = '0, ext_word = '0;
  logic [3:0]  treg_shift = '0;
  logic [31:0] acc;
  logic        carry, ovf, illegal;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] e_acc = '0;
  logic        e_c = 0, e_v = 0, e_ill = 0;

  always #10 clk = ~clk;

  acc_add_unit dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .mem_data(mem_data), .ext_valid(ext_valid), .ext_word(ext_word), .sxm_en(sxm_en),
    .treg_shift(treg_shift), .acc(acc), .carry(carry), .ovf(ovf), .illegal(illegal));

  function automatic logic [31:0] widen(logic [15:0] d, bit sx);
    return sx ? 32'($signed(d)) : {16'h0, d};
  endfunction

  task automatic model_add(logic [31:0] b, bit cin);
    longint s_signed;
    logic [32:0] s_unsigned;
    s_signed   = longint'($signed(e_acc)) + longint'($signed(b)) + longint'(cin);
    s_unsigned = 33'(e_acc) + 33'(b) + 33'(cin);
    e_acc = s_unsigned[31:0];
    e_c   = s_unsigned[32];
    e_v   = (s_signed > 64'sd2147483647) || (s_signed < -64'sd2147483648);
    e_ill = 0;
  endtask

  task automatic model_op(logic [15:0] op, logic [15:0] m, bit sx, logic [3:0] tr);
    casez (op)
      16'b0010_????_????_????: model_add(widen(m, sx) << op[11:8], 0);
      16'hBE00: begin
        e_ill = 0; e_c = 0;
        if (e_acc == 32'h8000_0000) begin e_acc = 32'h7FFF_FFFF; e_v = 1; end
        else begin e_v = 0; if (e_acc[31]) e_acc = 32'd0 - e_acc; end
      end
      16'h60??: model_add(widen(m, sx), e_c);
      16'h61??: model_add(widen(m, sx) << 16, 0);
      16'h62??: model_add({16'h0, m}, 0);
      16'h63??: model_add(widen(m, sx) << tr, 0);
      16'hB8??: model_add({24'h0, op[7:0]}, 0);
      default: e_ill = 1;
    endcase
  endtask

  task automatic check(string tag);
    checks++;
    if (acc !== e_acc || carry !== e_c || ovf !== e_v || illegal !== e_ill) begin
      errors++;
      $display("FAIL %s: acc=%h c=%b v=%b ill=%b expected acc=%h c=%b v=%b ill=%b",
               tag, acc, carry, ovf, illegal, e_acc, e_c, e_v, e_ill);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; op_valid = 0; ext_valid = 0;
    @(posedge clk); #5;
    @(negedge clk); rst_n = 1;
    e_acc = 0; e_c = 0; e_v = 0; e_ill = 0;
  endtask

  task automatic apply(logic [15:0] op, logic [15:0] m, bit sx, logic [3:0] tr, string tag);
    @(negedge clk);
    op_valid = 1; op_word = op; mem_data = m; sxm_en = sx; treg_shift = tr;
    model_op(op, m, sx, tr);
    @(posedge clk); #5;
    check(tag);
    op_valid = 0;
  endtask

  task automatic apply_long(logic [3:0] sh, logic [15:0] w, bit sx, string tag);
    @(negedge clk);
    op_valid = 1; op_word = {12'hBF9, sh}; mem_data = $urandom; sxm_en = sx;
    e_ill = 0;
    @(posedge clk); #5;
    check({tag, " R3 first word"});
    @(negedge clk);
    op_word = 16'h7ABC; ext_valid = 0;
    @(posedge clk); #5;
    check({tag, " R3 op ignored while waiting"});
    @(negedge clk);
    op_valid = 0; ext_valid = 1; ext_word = w;
    model_add(widen(w, sx) << sh, 0);
    @(posedge clk); #5;
    check({tag, " R3 second word"});
    @(negedge clk); ext_valid = 0;
  endtask

  function automatic logic [15:0] rand_op();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom_range(0, 8))
      0: return {4'b0010, r[11:0]};
      1: return {8'h60, r[7:0]};
      2: return {8'h61, r[7:0]};
      3: return {8'h62, r[7:0]};
      4: return {8'h63, r[7:0]};
      5: return {8'hB8, r[7:0]};
      6: return 16'hBE00;
      7: return {4'h7, r[11:0]};
      default: return {4'hD, r[11:0]};
    endcase
  endfunction

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(posedge clk);
    #5; check("R1 reset state");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5; check("R1 idle after reset");

    apply(16'h2000, 16'h0001, 1, 0, "R2 shift 0");
    apply(16'h2F00, 16'h8000, 1, 0, "R2 R9 shift 15 sign-extended");
    apply(16'h2300, 16'hFFFF, 0, 0, "R2 R9 zero-extended");
    apply(16'h6100, 16'h0002, 1, 0, "R4 shift 16");
    apply(16'hB8F3, 16'h0000, 1, 0, "R5 short immediate");
    apply(16'h6200, 16'h8001, 1, 0, "R7 no sign extension");
    apply(16'h6300, 16'hFFFE, 1, 4'd9, "R8 temporary-register shift");
    do_reset();
    apply(16'h2000, 16'hFFFF, 1, 0, "R10 all ones");
    apply(16'h2000, 16'h0001, 1, 0, "R10 carry out");
    apply(16'h6000, 16'h0000, 1, 0, "R6 carry-in added");
    apply(16'h6000, 16'h0000, 1, 0, "R6 carry-in clear");
    apply(16'h6100, 16'h7FFF, 1, 0, "R10 positive");
    apply(16'h2000, 16'h7FFF, 1, 0, "R10 near max");
    apply(16'h6100, 16'h0001, 1, 0, "R10 signed overflow");
    apply(16'h7123, 16'h1111, 1, 0, "R12 illegal no effect");
    apply(16'hBE01, 16'h0000, 1, 0, "R12 near-abs illegal");
    apply(16'hB800, 16'h0000, 1, 0, "R12 illegal cleared");
    apply(16'hBE00, 16'h0000, 1, 0, "R11 abs of negative");
    do_reset();
    apply(16'h6100, 16'h8000, 1, 0, "R11 build most negative");
    apply(16'hBE00, 16'h0000, 1, 0, "R11 abs saturates");
    apply(16'hBE00, 16'h0000, 1, 0, "R11 abs of positive");
    apply_long(4'd4, 16'h8765, 1, "R9 long sign");
    apply_long(4'd15, 16'hFFFF, 0, "R9 long zero");

    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0)
        apply_long(4'($urandom), 16'($urandom), 1'($urandom), "R3 random");
      else
        apply(rand_op(), 16'($urandom), 1'($urandom), 4'($urandom), "R10 random mix");
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule